// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a set of raw interrupt request wires into a registered pending-request vector. Each line has its own trigger mode. In level mode the pending bit follows the wire. In edge mode the pending bit is set by a low-to-high transition and stays set until the line is acknowledged. To see transitions, the block keeps the level that each wire had in the previous cycle.

A priority resolver downstream reads the pending vector and, when it grants a line, pulses the acknowledge strobe with that line's index. The trigger-mode register is written and read as a plain bus register. A fixed per-instance mask forces some lines to stay in edge mode. An initialization strobe restarts request capture without touching the trigger-mode register. All state changes on the rising clock edge. The request wires must already be synchronous to the clock.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `req_q` and `mode_q` both become all zeros (every line in edge mode).
- R2: A line whose `mode_q` bit is 1 (level mode) has its `req_q` bit equal, one cycle later, to the value its `irq_in` bit had.
- R3: A line whose `mode_q` bit is 0 (edge mode) gets its `req_q` bit set only when its `irq_in` bit is 1 and was 0 in the previous cycle. A wire held high after it has been acknowledged does not set the bit again.
- R4: An edge-mode request that is pending stays set while its wire is low and no acknowledge addresses it.
- R5: `ack_valid` high with `ack_idx` = k clears bit k of `req_q` on the next edge when line k is in edge mode. No other bit is affected.
- R6: An acknowledge addressed to a level-mode line has no effect. The bit stays set while the wire is high.
- R7: If an acknowledge and a new low-to-high transition reach the same edge-mode line in the same cycle, the request bit ends up set.
- R8: A write (`mode_wr` high) stores `mode_wdata & MODE_WR_MASK` into `mode_q`. With the default mask 0xF8, lines 0 to 2 always read back 0 (edge mode).
- R9: Without a write, `mode_q` keeps its value.
- R10: `init_clr` clears every request bit and every remembered level on the next edge, overriding same-cycle transitions. A wire still high afterwards is seen as a new transition on the following edge.
- R11: `init_clr` does not change `mode_q`. A mode write in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw request levels, already synchronous |
| ack_valid | input | 1 | Acknowledge strobe for one line |
| ack_idx | input | $clog2(NUM_LINES) | Index of the acknowledged line |
| mode_wr | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata | input | NUM_LINES | Write data; bit i = 1 selects level mode for line i |
| init_clr | input | 1 | Initialization: clears requests and remembered levels |
| req_q | output | NUM_LINES | Pending-request register |
| mode_q | output | NUM_LINES | Trigger-mode register read-back |

## Verification
A directed sequence runs with a mixed mode setting (lines 0 to 3 edge, 4 to 7 level). It separates the two modes through four patterns: a single pulse, a wire held high across an acknowledge, an acknowledge that lands together with a fresh rising edge, and an initialization while wires stay high. Together these show whether the remembered level is cleared, and which action wins on a collision. All 256 write values are swept through the mode register to expose any mask bit that leaks. A long pseudo-random run then mixes wire levels, acknowledges, mode writes and rare initializations, and checks both registers every cycle against an arithmetic model.

// File: rtl/irq_latch_pkg.sv
`timescale 1ns/1ps
// Package: shared trigger-mode encoding for the request latch.
package irq_latch_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irq_trig_mode_reg.sv
`timescale 1ns/1ps
// Trigger-mode register. Holds one mode bit per line; writes are ANDed with
// a fixed per-instance mask so masked lines stay edge-triggered. Assumes the
// initialization strobe of the latch never reaches this register.
module irq_trig_mode_reg #(
    parameter int                   NUM_LINES    = 8,
    parameter logic [NUM_LINES-1:0] MODE_WR_MASK = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mode_q
);

    // Store masked write data; clear only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_data & MODE_WR_MASK;
    end

    a_r8_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == ($past(wr_data) & MODE_WR_MASK)));

    a_r8_forced_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q & ~MODE_WR_MASK) == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/irq_ack_decode.sv
`timescale 1ns/1ps
// Acknowledge decoder: turns a strobe plus line index into one hit bit per
// line. Assumes an index past the last line simply hits nothing.
module irq_ack_decode #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] ack_hit
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
        // Assert the hit bit of the addressed line.
        always_comb ack_hit[i] = ack_valid && (ack_idx == IDX_W'(i));
    end

endmodule

// File: rtl/irq_line_cell.sv
`timescale 1ns/1ps
// One request line: keeps the pending bit and the level seen last cycle.
// Level mode copies the wire; edge mode sets on a rising transition and
// clears on acknowledge unless a new rise arrives in the same cycle.
// Assumes raw_in is synchronous to clk.
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_clr,
    input  trig_mode_e trig,
    input  logic       raw_in,
    input  logic       ack_hit,
    output logic       pend_q
);

    logic seen_q;
    logic rise;

    // Rising transition relative to the remembered level.
    always_comb rise = raw_in & ~seen_q;

    // Update pending bit and remembered level once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            pend_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= raw_in;
            if (trig == TRIG_LEVEL)
                pend_q <= raw_in;
            else
                pend_q <= rise | (pend_q & ~ack_hit);
        end
    end

    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LEVEL && !init_clr) |=> (pend_q == $past(raw_in)));

    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_EDGE && !init_clr && raw_in && !seen_q) |=> pend_q);

    a_r3_no_rise_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_EDGE && !init_clr && !pend_q && !(raw_in && !seen_q))
        |=> !pend_q);

    a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_EDGE && !init_clr && pend_q && !ack_hit) |=> pend_q);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_EDGE && !init_clr && ack_hit && !(raw_in && !seen_q))
        |=> !pend_q);

    a_r6_level_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LEVEL && !init_clr && ack_hit && raw_in) |=> pend_q);

    a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (!pend_q && !seen_q));

endmodule

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
// Edge/level interrupt request latch. One cell per line, a shared masked
// trigger-mode register and an acknowledge decoder. Initialization clears
// request state only. Assumes irq_in is already synchronous to clk.
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int                   NUM_LINES    = 8,
    parameter logic [NUM_LINES-1:0] MODE_WR_MASK = 8'hF8,
    localparam int                  IDX_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 mode_wr,
    input  logic [NUM_LINES-1:0] mode_wdata,
    input  logic                 init_clr,
    output logic [NUM_LINES-1:0] req_q,
    output logic [NUM_LINES-1:0] mode_q
);

    logic [NUM_LINES-1:0] ack_hit;

    irq_trig_mode_reg #(
        .NUM_LINES   (NUM_LINES),
        .MODE_WR_MASK(MODE_WR_MASK)
    ) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .wr_data(mode_wdata),
        .mode_q (mode_q)
    );

    irq_ack_decode #(
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W)
    ) u_ack (
        .ack_valid(ack_valid),
        .ack_idx  (ack_idx),
        .ack_hit  (ack_hit)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .init_clr(init_clr),
            .trig    (trig_mode_e'(mode_q[i])),
            .raw_in  (irq_in[i]),
            .ack_hit (ack_hit[i]),
            .pend_q  (req_q[i])
        );
    end

    a_r11_init_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (init_clr && !mode_wr) |=> $stable(mode_q));

    a_r10_init_empties: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (req_q == '0));

endmodule

// File: tb/irq_req_latch_bench.sv
`timescale 1ns/1ps
module irq_req_latch_bench;
    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       ack_valid;
    logic [2:0] ack_idx;
    logic       mode_wr;
    logic [7:0] mode_wdata;
    logic       init_clr;
    logic [7:0] req_q;
    logic [7:0] mode_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] req_m  = '0;
    logic [7:0] last_m = '0;
    logic [7:0] mode_m = '0;

    always #2.5 clk = ~clk;

    irq_req_latch u_irq_req_latch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .init_clr(init_clr), .req_q(req_q), .mode_q(mode_q)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, advance the model, return at next negedge.
    task automatic step(input logic [7:0] in, input logic av, input logic [2:0] ai,
                        input logic wr, input logic [7:0] wd, input logic ic);
        logic [7:0] nr;
        logic [7:0] nl;
        irq_in = in; ack_valid = av; ack_idx = ai;
        mode_wr = wr; mode_wdata = wd; init_clr = ic;
        for (int i = 0; i < 8; i++) begin
            if (ic) begin
                nr[i] = 1'b0; nl[i] = 1'b0;
            end else if (mode_m[i]) begin
                nr[i] = in[i]; nl[i] = in[i];
            end else begin
                nr[i] = (in[i] & ~last_m[i]) | (req_m[i] & ~(av && (ai == 3'(i))));
                nl[i] = in[i];
            end
        end
        if (wr) mode_m = wd & MASK;
        req_m = nr; last_m = nl;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        rst_n = 1'b0; irq_in = '0; ack_valid = 0; ack_idx = '0;
        mode_wr = 0; mode_wdata = '0; init_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset req", req_q, 8'h00);
        chk("R1 reset mode", mode_q, 8'h00);
        rst_n = 1'b1;

        step(8'h00, 0, 0, 1, 8'hF0, 0);  chk("R8 mode F0", mode_q, 8'hF0);
        step(8'h01, 0, 0, 0, 0, 0);      chk("R3 rise sets", req_q, 8'h01);
        step(8'h01, 0, 0, 0, 0, 0);      chk("R3 held", req_q, 8'h01);
        step(8'h00, 0, 0, 0, 0, 0);      chk("R4 pending low", req_q, 8'h01);
        step(8'h02, 0, 0, 0, 0, 0);      chk("R3 second line", req_q, 8'h03);
        step(8'h02, 1, 0, 0, 0, 0);      chk("R5 ack line0 only", req_q, 8'h02);
        step(8'h02, 1, 1, 0, 0, 0);      chk("R5 ack line1", req_q, 8'h00);
        step(8'h02, 0, 0, 0, 0, 0);      chk("R3 held high no reset", req_q, 8'h00);
        step(8'h00, 0, 0, 0, 0, 0);      chk("R3 low", req_q, 8'h00);
        step(8'h04, 1, 2, 0, 0, 0);      chk("R7 ack with rise", req_q, 8'h04);
        step(8'h00, 1, 2, 0, 0, 0);      chk("R5 ack clears", req_q, 8'h00);
        step(8'h10, 0, 0, 0, 0, 0);      chk("R2 level high", req_q, 8'h10);
        step(8'h10, 1, 4, 0, 0, 0);      chk("R6 level ack ignored", req_q, 8'h10);
        step(8'h00, 0, 0, 0, 0, 0);      chk("R2 level low", req_q, 8'h00);
        step(8'h1F, 0, 0, 0, 0, 0);      chk("R3 R2 mixed", req_q, 8'h1F);
        step(8'h1F, 0, 0, 0, 0, 1);      chk("R10 init clears", req_q, 8'h00);
        chk("R11 init keeps mode", mode_q, 8'hF0);
        step(8'h1F, 0, 0, 0, 0, 0);      chk("R10 level forgotten", req_q, 8'h1F);
        step(8'h1F, 0, 0, 1, 8'hFF, 1);  chk("R10 init with write", req_q, 8'h00);
        chk("R11 write during init", mode_q, 8'hF8);
        for (int k = 0; k < 5; k++) begin
            step(8'h00, 0, 0, 0, 8'h07, 0);
            chk("R9 mode holds", mode_q, 8'hF8);
        end
        for (int v = 0; v < 256; v++) begin
            step(8'h00, 0, 0, 1, 8'(v), 0);
            chk("R8 masked write", mode_q, 8'(v) & MASK);
        end

        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[7:0], lf[22], lf[25:23], lf[20:18] == 3'd0, lf[31:24],
                 lf[15:11] == 5'd0);
            chk("sweep R2 R3 R4 R5 R6 R7 R10", req_q, req_m);
            chk("sweep R8 R9 R11", mode_q, mode_m);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule